// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether a port I/O access is permitted by the permission bitmap held in the current 32-bit task state segment. The caller supplies the final 16-bit port number, an access width of one, two or four bytes, and the task register's cached base, limit, present bit and type. After a start pulse, the block first checks that the task segment is usable. It then fetches the bitmap base pointer from the segment and reads a 16-bit window of the bitmap. It answers with either allow or a general-protection fault, whose error code is always zero.

Memory is read through a simple request/valid port that returns little-endian 16-bit words from any byte address, aligned or not. The block always reads two bytes of bitmap, because the bits that cover a multi-byte access can straddle a byte boundary. For the same reason, it checks both of those bytes against the segment limit before it issues the read. It does not take part in privilege-level bypass or in choosing the port operand.

Top module: `iopb_checker`

## Requirements
- R1: When start is accepted and the segment is not present, its type is not 9, or its limit is below 103, the block reports a fault with done in the next cycle and issues no memory request.
- R2: An access size code of 2'b11 is a fault with no memory request. The codes 2'b00, 2'b01 and 2'b10 select 1, 2 and 4 bytes.
- R3: The first read fetches the 16-bit bitmap pointer at address task base + 0x66.
- R4: The second read fetches the word at task base + pointer + (port >> 3), with 32-bit wraparound.
- R5: If pointer + (port >> 3) + 1 exceeds the task limit, the result is a fault after the first read only. Equality with the limit is still in range.
- R6: The window word is little-endian (the lower address is bits 7:0). It is shifted right by port[2:0], and its low 1, 2 or 4 bits are inspected. The access is allowed only when all of those bits are zero; otherwise it faults.
- R7: done is a single-cycle pulse. At most one of allow and fault is ever high, and both hold their value until the next accepted start, which clears them.
- R8: While a read is outstanding, the request and its address stay unchanged until a valid response arrives, for any response delay.
- R9: A start pulse that arrives while a check is in progress is ignored, and the running check completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check (accepted when idle) |
| io_port | input | 16 | Port number being accessed |
| io_size | input | 2 | Access width code |
| seg_base | input | 32 | Task segment linear base |
| seg_limit | input | 32 | Task segment byte limit |
| seg_present | input | 1 | Task segment present bit |
| seg_type | input | 4 | Task segment descriptor type |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Byte address of the 16-bit read |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Little-endian read data |
| done | output | 1 | One-cycle completion pulse |
| allow | output | 1 | Access permitted |
| fault | output | 1 | General-protection fault (error code 0) |

## Verification
The bench drives permission fields that straddle a byte boundary in both directions. A design that reads only one byte, or swaps the two bytes of the word, would wrongly allow or deny those accesses. It probes the window bound at exactly the limit and one past it, so an off-by-one comparison shows up as a spurious fault or as a read outside the segment. The bench also places the pointer at an odd address, varies the response delay, and pokes start while a check is busy. These catch an aligned-only fetch, a request dropped before valid, and operands overwritten in mid-check.

// File: rtl/iopb_pkg.sv
package iopb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PTR  = 2'd1,
        ST_MAP  = 2'd2
    } iopb_state_e;

    localparam logic [1:0] SZ_BYTE  = 2'b00;
    localparam logic [1:0] SZ_WORD  = 2'b01;
    localparam logic [1:0] SZ_DWORD = 2'b10;
    localparam logic [1:0] SZ_BAD   = 2'b11;

endpackage

// File: rtl/iopb_desc_gate.sv
module iopb_desc_gate #(
    parameter int LIM_W     = 32,
    parameter int TYPE_W    = 4,
    parameter int GOOD_TYPE = 9,
    parameter int MIN_LIMIT = 103
) (
    input  logic              present,
    input  logic [TYPE_W-1:0] seg_type,
    input  logic [LIM_W-1:0]  limit,
    input  logic [1:0]        size_code,
    output logic              usable
);
    import iopb_pkg::*;

    localparam logic [TYPE_W-1:0] TYPE_OK = TYPE_W'(GOOD_TYPE);
    localparam logic [LIM_W-1:0]  LIM_MIN = LIM_W'(MIN_LIMIT);

    always_comb begin
        usable = present
              && (seg_type == TYPE_OK)
              && (limit >= LIM_MIN)
              && (size_code != SZ_BAD);
    end
endmodule

// File: rtl/iopb_window_bound.sv
module iopb_window_bound #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 16,
    parameter int PORT_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [WORD_W-1:0] map_ptr,
    input  logic [PORT_W-1:0] port,
    output logic              in_range,
    output logic [ADDR_W-1:0] win_addr
);
    localparam int OFF_W  = WORD_W + 1;
    localparam int IDX_W  = PORT_W - 3;

    logic [OFF_W-1:0]  offset;
    logic [ADDR_W-1:0] offset_ext;
    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        offset     = {1'b0, map_ptr} + {{(OFF_W-IDX_W){1'b0}}, port[PORT_W-1:3]};
        offset_ext = {{(ADDR_W-OFF_W){1'b0}}, offset};
        last_byte  = offset_ext + ADDR_W'(1);
        in_range   = (last_byte <= limit);
        win_addr   = base + offset_ext;
    end
endmodule

// File: rtl/iopb_window_eval.sv
module iopb_window_eval #(
    parameter int WORD_W  = 16,
    parameter int FIELD_W = 4
) (
    input  logic [WORD_W-1:0] window,
    input  logic [2:0]        bit_ofs,
    input  logic [1:0]        size_code,
    output logic              permit
);
    import iopb_pkg::*;

    logic [WORD_W-1:0]  shifted;
    logic [FIELD_W-1:0] enable;
    logic [FIELD_W-1:0] hit;
    int unsigned        nbits;

    always_comb begin
        shifted = window >> bit_ofs;
        case (size_code)
            SZ_BYTE:  nbits = 1;
            SZ_WORD:  nbits = 2;
            SZ_DWORD: nbits = 4;
            default:  nbits = FIELD_W;
        endcase
    end

    for (genvar i = 0; i < FIELD_W; i++) begin : g_field
        assign enable[i] = (i < nbits);
        assign hit[i]    = enable[i] & shifted[i];
    end

    assign permit = (hit == '0);
endmodule

// File: rtl/iopb_checker.sv
module iopb_checker #(
    parameter int ADDR_W    = 32,
    parameter int PORT_W    = 16,
    parameter int WORD_W    = 16,
    parameter int TYPE_W    = 4,
    parameter int GOOD_TYPE = 9,
    parameter int MIN_LIMIT = 103,
    parameter int PTR_OFS   = 'h66
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       io_port,
    input  logic [1:0]        io_size,
    input  logic [31:0]       seg_base,
    input  logic [31:0]       seg_limit,
    input  logic              seg_present,
    input  logic [3:0]        seg_type,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_valid,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    output logic              allow,
    output logic              fault
);
    import iopb_pkg::*;

    localparam logic [ADDR_W-1:0] PTR_ADDR_OFS = ADDR_W'(PTR_OFS);

    typedef struct packed {
        iopb_state_e        state;
        logic [PORT_W-1:0]  port;
        logic [1:0]         size;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  limit;
        logic [ADDR_W-1:0]  addr;
        logic               done;
        logic               allow;
        logic               fault;
    } chk_regs_t;

    chk_regs_t r_q, r_d;

    logic              gate_ok;
    logic              win_in_range;
    logic [ADDR_W-1:0] win_addr;
    logic              win_permit;

    iopb_desc_gate #(
        .LIM_W    (ADDR_W),
        .TYPE_W   (TYPE_W),
        .GOOD_TYPE(GOOD_TYPE),
        .MIN_LIMIT(MIN_LIMIT)
    ) u_gate (
        .present  (seg_present),
        .seg_type (seg_type),
        .limit    (seg_limit),
        .size_code(io_size),
        .usable   (gate_ok)
    );

    iopb_window_bound #(
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W),
        .PORT_W(PORT_W)
    ) u_bound (
        .base    (r_q.base),
        .limit   (r_q.limit),
        .map_ptr (mem_rdata),
        .port    (r_q.port),
        .in_range(win_in_range),
        .win_addr(win_addr)
    );

    iopb_window_eval #(
        .WORD_W (WORD_W),
        .FIELD_W(4)
    ) u_eval (
        .window   (mem_rdata),
        .bit_ofs  (r_q.port[2:0]),
        .size_code(r_q.size),
        .permit   (win_permit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.allow = 1'b0;
                    r_d.fault = 1'b0;
                    r_d.port  = io_port;
                    r_d.size  = io_size;
                    r_d.base  = seg_base;
                    r_d.limit = seg_limit;
                    if (!gate_ok) begin
                        r_d.fault = 1'b1;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.addr  = seg_base + PTR_ADDR_OFS;
                        r_d.state = ST_PTR;
                    end
                end
            end
            ST_PTR: begin
                if (mem_valid) begin
                    if (!win_in_range) begin
                        r_d.fault = 1'b1;
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.addr  = win_addr;
                        r_d.state = ST_MAP;
                    end
                end
            end
            ST_MAP: begin
                if (mem_valid) begin
                    r_d.allow = win_permit;
                    r_d.fault = !win_permit;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = (r_q.state != ST_IDLE);
    assign mem_addr = r_q.addr;
    assign done     = r_q.done;
    assign allow    = r_q.allow;
    assign fault    = r_q.fault;

    // R1: a segment rejected by the gate faults at once and never reads
    assert_fast_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start && !gate_ok) |=> (done && fault && !mem_req));

    // R2: the reserved size code never leads to a read
    assert_bad_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && start && io_size == SZ_BAD) |=> (fault && !mem_req));

    // R5: a window past the limit ends the check after the pointer read
    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_PTR && mem_valid && !win_in_range) |=> (done && fault && !mem_req));

    // R6: the bitmap read always completes the check
    assert_map_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_MAP && mem_valid) |=> (done && (allow != fault)));

    // R7: done lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: allow and fault are never both set
    assert_result_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(allow && fault));

    // R7: results change only at a start or a completion
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (done || ($stable(allow) && $stable(fault))));

    // R8: request and address hold until the response arrives
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R9: while busy the previous result stays cleared
    assert_busy_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!allow && !fault));

endmodule

// File: tb/iopb_checker_test.sv
module iopb_checker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] io_port = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] seg_base = '0;
    logic [31:0] seg_limit = '0;
    logic        seg_present = 1'b0;
    logic [3:0]  seg_type = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic        allow;
    logic        fault;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int lat = 0;
    int wait_cnt = 0;
    bit in_txn = 0;
    bit wd_fired = 0;
    logic [31:0] addr_log[$];
    logic [7:0]  mem[int unsigned];

    always #2 clk = ~clk;

    iopb_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .io_port(io_port), .io_size(io_size),
        .seg_base(seg_base), .seg_limit(seg_limit),
        .seg_present(seg_present), .seg_type(seg_type),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .done(done), .allow(allow), .fault(fault)
    );

    function automatic logic [7:0] rd8(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    function automatic logic [15:0] rd16(logic [31:0] a);
        return {rd8(a + 32'd1), rd8(a)};
    endfunction

    task automatic put16(logic [31:0] a, logic [15:0] v);
        mem[a] = v[7:0];
        mem[a + 32'd1] = v[15:8];
    endtask

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // memory responder: drives away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (mem_valid) begin
            mem_valid = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = rd16(mem_addr);
                addr_log.push_back(mem_addr);
            end else begin
                wait_cnt++;
            end
        end
        if (rst_n && done && !in_txn)
            chk(0, "R7", "done outside check", 1, 0);
        if (rst_n && allow && fault)
            chk(0, "R7", "allow and fault both set", 1, 0);
        if (cyc > 100000 && !wd_fired) begin
            wd_fired = 1;
            chk(0, "R8", "watchdog cycles", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // behavioural reference of a whole check
    task automatic run(string tag, logic [15:0] p, logic [1:0] sz, logic [31:0] b,
                       logic [31:0] l, logic pr, logic [3:0] ty, int latency, bit poke);
        bit          exp_allow;
        int          exp_reads;
        logic [31:0] a0, a1;
        int          cycles;
        int          nb;
        logic [15:0] w;
        longint      off;
        bit          saw_done;
        exp_allow = 0; exp_reads = 0; a0 = '0; a1 = '0;
        if (pr && ty == 4'd9 && l >= 32'd103 && sz != 2'b11) begin
            a0 = b + 32'h66;
            exp_reads = 1;
            off = longint'(rd16(a0)) + longint'(p >> 3);
            if (off + 1 <= longint'(l)) begin
                exp_reads = 2;
                a1 = b + 32'(off);
                w = rd16(a1);
                nb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
                exp_allow = (((w >> p[2:0]) & 16'((1 << nb) - 1)) == 16'h0);
            end
        end

        @(negedge clk);
        addr_log.delete();
        lat = latency;
        wait_cnt = 0;
        in_txn = 1;
        io_port = p; io_size = sz; seg_base = b; seg_limit = l;
        seg_present = pr; seg_type = ty; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 1;
        if (poke && !done) begin
            // R9: new start while busy, with operands that would fail at once
            start = 1'b1; seg_present = 1'b0; io_port = ~p; io_size = 2'b11;
            @(negedge clk);
            start = 1'b0;
            cycles++;
        end
        while (!done && cycles < 500) begin
            @(negedge clk);
            cycles++;
        end
        saw_done = done;
        chk(saw_done, tag, "done seen", saw_done, 1);
        chk(allow == exp_allow, tag, "allow", allow, exp_allow);
        chk(fault == !exp_allow, tag, "fault", fault, !exp_allow);
        chk(addr_log.size() == exp_reads, tag, "read count", addr_log.size(), exp_reads);
        if (exp_reads == 0)
            chk(cycles == 1, tag, "fast fault latency", cycles, 1);
        if (exp_reads >= 1 && addr_log.size() >= 1)
            chk(addr_log[0] == a0, {tag, " R3"}, "pointer addr", addr_log[0], a0);
        if (exp_reads == 2 && addr_log.size() == 2)
            chk(addr_log[1] == a1, {tag, " R4"}, "window addr", addr_log[1], a1);
        @(negedge clk);
        chk(!done, "R7", "done pulse width", done, 0);
        in_txn = 0;
        repeat (2) @(negedge clk);
        chk(allow == exp_allow && fault == !exp_allow, "R7", "result hold",
            {allow, fault}, {exp_allow, !exp_allow});
    endtask

    localparam logic [31:0] B1 = 32'h0000_1000;
    localparam logic [31:0] B2 = 32'h0000_2001;
    localparam logic [31:0] LBIG = 32'h0000_2000;

    initial begin
        // bitmap image, segment 1: pointer 0x68
        put16(B1 + 32'h66, 16'h0068);
        mem[B1 + 32'h68] = 8'h00;
        mem[B1 + 32'h69] = 8'h80;
        mem[B1 + 32'h6A] = 8'h00;
        mem[B1 + 32'h6B] = 8'h01;
        mem[B1 + 32'h6C] = 8'h00;
        mem[B1 + 32'h6D] = 8'h00;
        mem[B1 + 32'h6E] = 8'h00;
        mem[B1 + 32'h6F] = 8'h02;
        mem[B1 + 32'h70] = 8'h00;
        // segment 2: odd base and odd pointer
        put16(B2 + 32'h66, 16'h0081);
        mem[B2 + 32'h81] = 8'h10;

        repeat (3) @(negedge clk);
        chk(!done && !allow && !fault && !mem_req, "R7", "reset state",
            {done, allow, fault, mem_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run("R1", 16'h0003, 2'b00, B1, LBIG, 1'b0, 4'd9, 0, 0);
        run("R1", 16'h0003, 2'b00, B1, LBIG, 1'b1, 4'd1, 0, 0);
        run("R1", 16'h0003, 2'b00, B1, 32'd102, 1'b1, 4'd9, 0, 0);
        run("R5", 16'h0003, 2'b00, B1, 32'd103, 1'b1, 4'd9, 1, 0);
        run("R2", 16'h0003, 2'b11, B1, LBIG, 1'b1, 4'd9, 0, 0);
        run("R6", 16'h0003, 2'b00, B1, LBIG, 1'b1, 4'd9, 0, 0);
        run("R6", 16'h000F, 2'b00, B1, LBIG, 1'b1, 4'd9, 0, 0);
        run("R6", 16'h0017, 2'b01, B1, LBIG, 1'b1, 4'd9, 2, 0);
        run("R6", 16'h0027, 2'b01, B1, LBIG, 1'b1, 4'd9, 0, 0);
        run("R6", 16'h0036, 2'b10, B1, LBIG, 1'b1, 4'd9, 0, 0);
        run("R6", 16'h003E, 2'b10, B1, LBIG, 1'b1, 4'd9, 0, 0);
        run("R6", 16'h0030, 2'b10, B1, LBIG, 1'b1, 4'd9, 0, 0);
        run("R5", 16'h0040, 2'b00, B1, 32'h71, 1'b1, 4'd9, 0, 0);
        run("R5", 16'h0040, 2'b00, B1, 32'h70, 1'b1, 4'd9, 0, 0);
        run("R5", 16'hFFFF, 2'b00, B1, LBIG, 1'b1, 4'd9, 0, 0);
        run("R4", 16'h0004, 2'b00, B2, LBIG, 1'b1, 4'd9, 0, 0);
        run("R4", 16'h0005, 2'b00, B2, LBIG, 1'b1, 4'd9, 0, 0);
        run("R8", 16'h000F, 2'b00, B1, LBIG, 1'b1, 4'd9, 7, 0);
        run("R8", 16'h0027, 2'b01, B1, LBIG, 1'b1, 4'd9, 3, 0);
        run("R9", 16'h0003, 2'b00, B1, LBIG, 1'b1, 4'd9, 5, 1);
        run("R9", 16'h0017, 2'b01, B1, LBIG, 1'b1, 4'd9, 5, 1);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule